// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block brings five supply rails of a discrete accelerator up and down in a fixed order. For every rail it drives the regulator enable and watches the regulator's power-good line. It also owns two device-level signals: a combined "all rails good" indication and an active-low device reset. A single request port with a direction bit (up or down) starts a sequence. The block confirms acceptance with a one-cycle acknowledge.

Rails are numbered 0 to 4: 1.8 V auxiliary, 3.3 V, core plus memory subsystem, PCIe interface, framebuffer. Bringing up walks the rails upward, and shutting down walks them downward. Each power-good wait is bounded by a timeout. Some rails have a settle pause after shutdown. A timeout while bringing up turns into a complete shutdown. All waits count a microsecond tick that is derived from the clock-frequency parameter.

Top module: `rail_sequencer`

## Requirements
- R1: After reset every rail is disabled (`rail_en` = 5'b10000, since rail 4 is active-low), `all_good` = 0, `dev_rst_n` = 0, and `busy`, `ack`, `powered_on` and `fault` are all 0.
- R2: A `req` sampled high while `busy` is 0 is accepted. In the next cycle `ack` is high for exactly one cycle and `busy` is high. A `req` sampled while `busy` is 1 is ignored: it gives no `ack` and does not change the running sequence.
- R3: An accepted power-up (`req_on` = 1) first holds `dev_rst_n` low for one cycle with no rail enabled. It then enables the rails one at a time in index order 0 to 4. A rail is enabled only after the synchronised power-good of the previous rail reads 1.
- R4: The enable of rail 4 is active-low (0 means on). Rails 0 to 3 are active-high.
- R5: Each `pg` bit passes through two flops before the sequencer acts on it.
- R6: A rail whose synchronised power-good has not reached the target after TIMEOUT_US ticks has timed out. If the target is reached in the same cycle the limit is hit, the rail counts as good.
- R7: On a power-up timeout the block sets `fault` and puts the rail index in `fault_rail`. It then runs the full power-down sequence and stops idle with `all_good` = 0, `dev_rst_n` = 0 and `powered_on` = 0.
- R8: After rail 4 is good, `all_good` rises. GAP_US ticks later `dev_rst_n` rises. After a further GAP_US ticks `powered_on` is set and `busy` falls.
- R9: An accepted power-down (`req_on` = 0) drops `dev_rst_n` and `all_good` and clears `powered_on`. It then disables rails 4 down to 0. Each rail waits for its power-good to read 0 (or time out), then pauses for that rail's settle time (bench: 0, 4, 2, 10, 0 µs for rails 0 to 4).
- R10: A power-down timeout sets `fault`, and the sequence still carries on to rail 0. Only the first fault of a sequence is kept in `fault_rail`.
- R11: `fault` and `fault_rail` hold their values while idle and are cleared when the next request is accepted.
- R12: The microsecond tick fires once every CLK_HZ/1,000,000 clocks, and all timeout, gap and settle counts advance only on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Sequence request |
| req_on | input | 1 | Direction of the request: 1 power-up, 0 power-down |
| pg | input | 5 | Raw power-good per rail (asynchronous) |
| ack | output | 1 | One-cycle acceptance pulse |
| busy | output | 1 | A sequence is running |
| powered_on | output | 1 | Power-up completed successfully |
| fault | output | 1 | A power-good timeout happened in the last sequence |
| fault_rail | output | 3 | Index of the first rail that timed out |
| rail_en | output | 5 | Regulator enables, polarity per rail |
| all_good | output | 1 | Combined rails-good indication to the device |
| dev_rst_n | output | 1 | Active-low device reset |

## Verification
The delicate coincidence is a power-good arriving in the same cycle that its timeout count reaches the limit. The bench sweeps the regulator response latency of rail 0 across that boundary, one cycle at a time. The cycle model in the bench decides each outcome and so judges whether the rail was declared good or faulty. A second coincidence is a request held high across the cycle in which `busy` falls. This must be accepted on the very next edge.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_UP_START  = 3'd1,
    ST_UP_RAIL   = 3'd2,
    ST_UP_GOOD   = 3'd3,
    ST_UP_REL    = 3'd4,
    ST_DN_START  = 3'd5,
    ST_DN_RAIL   = 3'd6,
    ST_DN_SETTLE = 3'd7
  } seq_state_e;

  localparam int unsigned HZ_PER_MHZ = 1000000;

endpackage

// File: rtl/rail_seq_tick.sv
module rail_seq_tick #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import rail_seq_pkg::*;

  localparam int unsigned DIV = (CLK_HZ / HZ_PER_MHZ < 1) ? 1 : CLK_HZ / HZ_PER_MHZ;
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pcnt_q, pcnt_d;

  // R12: one pulse per DIV clocks
  assign tick = (pcnt_q == PW'(DIV - 1));

  always_comb begin
    pcnt_d = tick ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/rail_seq_pgsync.sv
module rail_seq_pgsync #(
  parameter int N_RAILS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] pg_raw,
  output logic [N_RAILS-1:0] pg_sync
);
  // R5: two capture flops per rail
  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pg_raw[g];
        s2_q <= s1_q;
      end
    end
    assign pg_sync[g] = s2_q;
  end
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm #(
  parameter int                    N_RAILS    = 5,
  parameter int unsigned           TIMEOUT_US = 20000,
  parameter int unsigned           GAP_US     = 1000,
  parameter logic [N_RAILS*32-1:0] OFF_DLY_US = {32'd0, 32'd10000, 32'd2000, 32'd4000, 32'd0},
  parameter logic [N_RAILS-1:0]    EN_ACT_LOW = 5'b10000,
  localparam int                   IW         = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               req,
  input  logic               req_on,
  input  logic [N_RAILS-1:0] pg_s,
  output logic               ack,
  output logic               busy,
  output logic               powered_on,
  output logic               fault,
  output logic [IW-1:0]      fault_rail,
  output logic [N_RAILS-1:0] rail_en,
  output logic               all_good,
  output logic               dev_rst_n
);
  import rail_seq_pkg::*;

  function automatic int unsigned lim_max();
    int unsigned m;
    m = TIMEOUT_US;
    if (GAP_US > m) m = GAP_US;
    for (int k = 0; k < N_RAILS; k++) begin
      if (OFF_DLY_US[k*32 +: 32] > m) m = OFF_DLY_US[k*32 +: 32];
    end
    return m;
  endfunction

  localparam int TW = $clog2(lim_max() + 2);
  localparam logic [TW-1:0] TO_LIM  = TW'(TIMEOUT_US);
  localparam logic [TW-1:0] GAP_LIM = TW'(GAP_US);
  localparam logic [IW-1:0] LAST    = IW'(N_RAILS - 1);

  function automatic logic [TW-1:0] settle_of(input logic [IW-1:0] r);
    logic [TW-1:0] v;
    v = '0;
    for (int k = 0; k < N_RAILS; k++) begin
      if (r == IW'(k)) v = TW'(OFF_DLY_US[k*32 +: 32]);
    end
    return v;
  endfunction

  seq_state_e          st_q, st_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic [N_RAILS-1:0]  on_q, on_d;
  logic                ag_q, ag_d;
  logic                rstn_q, rstn_d;
  logic                pon_q, pon_d;
  logic                flt_q, flt_d;
  logic [IW-1:0]       frail_q, frail_d;
  logic                ack_q, ack_d;
  logic [TW-1:0]       tmr_q, tmr_d;
  logic                cur_pg;
  logic                moved;

  assign cur_pg = pg_s[idx_q];

  // next-state process
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    on_d    = on_q;
    ag_d    = ag_q;
    rstn_d  = rstn_q;
    pon_d   = pon_q;
    flt_d   = flt_q;
    frail_d = frail_q;
    ack_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin                       // R2, R11
          ack_d   = 1'b1;
          flt_d   = 1'b0;
          frail_d = '0;
          pon_d   = 1'b0;
          rstn_d  = 1'b0;
          ag_d    = 1'b0;
          st_d    = req_on ? ST_UP_START : ST_DN_START;
        end
      end
      ST_UP_START: begin                     // R3: reset low before any rail
        st_d      = ST_UP_RAIL;
        idx_d     = '0;
        on_d[0]   = 1'b1;
      end
      ST_UP_RAIL: begin
        if (cur_pg) begin                    // R6: good wins over timeout
          if (idx_q == LAST) begin
            st_d = ST_UP_GOOD;
            ag_d = 1'b1;
          end else begin
            idx_d        = idx_q + 1'b1;
            on_d[idx_d]  = 1'b1;
          end
        end else if (tmr_q == TO_LIM) begin  // R7: roll back
          flt_d   = 1'b1;
          frail_d = idx_q;
          st_d    = ST_DN_START;
        end
      end
      ST_UP_GOOD: begin                      // R8
        if (tmr_q == GAP_LIM) begin
          rstn_d = 1'b1;
          st_d   = ST_UP_REL;
        end
      end
      ST_UP_REL: begin
        if (tmr_q == GAP_LIM) begin
          pon_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_DN_START: begin                     // R9
        rstn_d      = 1'b0;
        ag_d        = 1'b0;
        idx_d       = LAST;
        on_d[LAST]  = 1'b0;
        st_d        = ST_DN_RAIL;
      end
      ST_DN_RAIL: begin
        if (!cur_pg) begin
          st_d = ST_DN_SETTLE;
        end else if (tmr_q == TO_LIM) begin  // R10: note and carry on
          if (!flt_q) begin
            flt_d   = 1'b1;
            frail_d = idx_q;
          end
          st_d = ST_DN_SETTLE;
        end
      end
      ST_DN_SETTLE: begin
        if (tmr_q == settle_of(idx_q)) begin
          if (idx_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            idx_d       = idx_q - 1'b1;
            on_d[idx_d] = 1'b0;
            st_d        = ST_DN_RAIL;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // R12: wait counter restarts on every step, advances only on tick
  assign moved = (st_d != st_q) || (idx_d != idx_q);

  always_comb begin
    if (moved)                         tmr_d = '0;
    else if (tick && (tmr_q != '1))    tmr_d = tmr_q + 1'b1;
    else                               tmr_d = tmr_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      on_q    <= '0;
      ag_q    <= 1'b0;
      rstn_q  <= 1'b0;
      pon_q   <= 1'b0;
      flt_q   <= 1'b0;
      frail_q <= '0;
      ack_q   <= 1'b0;
      tmr_q   <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      on_q    <= on_d;
      ag_q    <= ag_d;
      rstn_q  <= rstn_d;
      pon_q   <= pon_d;
      flt_q   <= flt_d;
      frail_q <= frail_d;
      ack_q   <= ack_d;
      tmr_q   <= tmr_d;
    end
  end

  // R4: per-rail enable polarity
  assign rail_en    = on_q ^ EN_ACT_LOW;
  assign busy       = (st_q != ST_IDLE);
  assign ack        = ack_q;
  assign powered_on = pon_q;
  assign fault      = flt_q;
  assign fault_rail = frail_q;
  assign all_good   = ag_q;
  assign dev_rst_n  = rstn_q;
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int unsigned           CLK_HZ     = 100_000_000,
  parameter int                    N_RAILS    = 5,
  parameter int unsigned           TIMEOUT_US = 20000,
  parameter int unsigned           GAP_US     = 1000,
  parameter logic [N_RAILS*32-1:0] OFF_DLY_US = {32'd0, 32'd10000, 32'd2000, 32'd4000, 32'd0},
  parameter logic [N_RAILS-1:0]    EN_ACT_LOW = 5'b10000,
  localparam int                   IW         = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_on,
  input  logic [N_RAILS-1:0] pg,
  output logic               ack,
  output logic               busy,
  output logic               powered_on,
  output logic               fault,
  output logic [IW-1:0]      fault_rail,
  output logic [N_RAILS-1:0] rail_en,
  output logic               all_good,
  output logic               dev_rst_n
);
  logic               tick;
  logic [N_RAILS-1:0] pg_s;

  rail_seq_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rail_seq_pgsync #(.N_RAILS(N_RAILS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pg_raw (pg),
    .pg_sync(pg_s)
  );

  rail_seq_fsm #(
    .N_RAILS   (N_RAILS),
    .TIMEOUT_US(TIMEOUT_US),
    .GAP_US    (GAP_US),
    .OFF_DLY_US(OFF_DLY_US),
    .EN_ACT_LOW(EN_ACT_LOW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .req       (req),
    .req_on    (req_on),
    .pg_s      (pg_s),
    .ack       (ack),
    .busy      (busy),
    .powered_on(powered_on),
    .fault     (fault),
    .fault_rail(fault_rail),
    .rail_en   (rail_en),
    .all_good  (all_good),
    .dev_rst_n (dev_rst_n)
  );
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int N_RAILS = 5,
  parameter int IW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               ack,
  input logic               busy,
  input logic               powered_on,
  input logic               fault,
  input logic [IW-1:0]      fault_rail,
  input logic [N_RAILS-1:0] rail_en,
  input logic               all_good,
  input logic               dev_rst_n
);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_ack_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy);

  a_r2_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !ack);

  a_r3_one_rail_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rail_en ^ $past(rail_en)));

  a_r8_release_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_n |-> all_good);

  a_r8_on_means_released: assert property (@(posedge clk) disable iff (!rst_n)
    powered_on |-> (dev_rst_n && all_good && !busy));

  a_r7_fault_holds_device: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!all_good && !dev_rst_n));

  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> ($stable(fault) && $stable(fault_rail)));
endmodule

bind rail_sequencer rail_sequencer_chk #(.N_RAILS(N_RAILS), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .ack       (ack),
  .busy      (busy),
  .powered_on(powered_on),
  .fault     (fault),
  .fault_rail(fault_rail),
  .rail_en   (rail_en),
  .all_good  (all_good),
  .dev_rst_n (dev_rst_n)
);

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;
  localparam int unsigned HZ  = 4_000_000;
  localparam int          DV  = 4;
  localparam int          TO  = 30;
  localparam int          GAP = 3;
  localparam logic [4:0]  ACTLOW = 5'b10000;
  int dly [5] = '{0, 4, 2, 10, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       req_on = 1'b0;
  logic [4:0] pg = '0;
  logic       ack, busy, powered_on, fault, all_good, dev_rst_n;
  logic [2:0] fault_rail;
  logic [4:0] rail_en;

  int vectors = 0;
  int miscmp  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  rail_sequencer #(
    .CLK_HZ(HZ), .N_RAILS(5), .TIMEOUT_US(TO), .GAP_US(GAP),
    .OFF_DLY_US({32'd0, 32'd10, 32'd2, 32'd4, 32'd0}), .EN_ACT_LOW(ACTLOW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_on(req_on), .pg(pg),
    .ack(ack), .busy(busy), .powered_on(powered_on), .fault(fault),
    .fault_rail(fault_rail), .rail_en(rail_en), .all_good(all_good),
    .dev_rst_n(dev_rst_n)
  );

  // ---------------- regulator model ----------------
  int   lat [5] = '{2, 5, 1, 7, 3};
  bit   stuck_lo [5] = '{0, 0, 0, 0, 0};
  bit   stuck_hi [5] = '{0, 0, 0, 0, 0};
  bit   prev_lg [5] = '{0, 0, 0, 0, 0};
  int   age [5] = '{1000, 1000, 1000, 1000, 1000};

  always @(negedge clk) begin
    for (int i = 0; i < 5; i++) begin
      bit lg;
      bit v;
      lg = rail_en[i] ^ ACTLOW[i];
      if (lg != prev_lg[i]) age[i] = 0;
      else if (age[i] < 1000000) age[i] = age[i] + 1;
      prev_lg[i] = lg;
      v = (age[i] >= lat[i]) ? lg : !lg;
      if (stuck_lo[i]) v = 1'b0;
      if (stuck_hi[i]) v = 1'b1;
      pg[i] = v;
    end
  end

  // ---------------- cycle reference model ----------------
  // phases: 0 idle, 1 up-start, 2 up-rail, 3 up-good, 4 up-release,
  //         5 down-start, 6 down-rail, 7 down-settle
  int   m_pc, m_st, m_i, m_tmr, m_frail;
  bit   m_on [5];
  bit   m_ag, m_rstn, m_pon, m_flt, m_ack;
  logic [4:0] m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_st = 0; m_i = 0; m_tmr = 0; m_frail = 0;
      for (int k = 0; k < 5; k++) m_on[k] = 0;
      m_ag = 0; m_rstn = 0; m_pon = 0; m_flt = 0; m_ack = 0;
      m_s1 = '0; m_s2 = '0;
    end else begin
      bit   tk;
      int   ost, oi;
      logic [4:0] seen;
      tk = (m_pc == DV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      seen = m_s2;
      ost = m_st; oi = m_i;
      m_ack = 0;
      case (ost)
        0: if (req) begin
             m_ack = 1; m_flt = 0; m_frail = 0; m_pon = 0; m_rstn = 0; m_ag = 0;
             m_st = req_on ? 1 : 5;
           end
        1: begin m_st = 2; m_i = 0; m_on[0] = 1; end
        2: if (seen[oi]) begin
             if (oi == 4) begin m_st = 3; m_ag = 1; end
             else begin m_i = oi + 1; m_on[oi + 1] = 1; end
           end else if (m_tmr == TO) begin
             m_flt = 1; m_frail = oi; m_st = 5;
           end
        3: if (m_tmr == GAP) begin m_rstn = 1; m_st = 4; end
        4: if (m_tmr == GAP) begin m_pon = 1; m_st = 0; end
        5: begin m_rstn = 0; m_ag = 0; m_i = 4; m_on[4] = 0; m_st = 6; end
        6: if (!seen[oi]) m_st = 7;
           else if (m_tmr == TO) begin
             if (!m_flt) begin m_flt = 1; m_frail = oi; end
             m_st = 7;
           end
        default: if (m_tmr == dly[oi]) begin
             if (oi == 0) m_st = 0;
             else begin m_i = oi - 1; m_on[oi - 1] = 0; m_st = 6; end
           end
      endcase
      if (m_st != ost || m_i != oi) m_tmr = 0;
      else if (tk) m_tmr = m_tmr + 1;
      m_s2 = m_s1;
      m_s1 = pg;
    end
  end

  function automatic logic [4:0] m_en();
    logic [4:0] e;
    for (int k = 0; k < 5; k++) e[k] = m_on[k] ^ ACTLOW[k];
    return e;
  endfunction

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rail_en !== m_en()) begin
        miscmp++;
        $display("FAIL R3/R4/R5/R9/R12 rail_en act=%b exp=%b cyc=%0d", rail_en, m_en(), cyc);
      end
      if ({ack, busy} !== {m_ack, (m_st != 0)}) begin
        miscmp++;
        $display("FAIL R2 ack/busy act=%b%b exp=%b%b cyc=%0d", ack, busy, m_ack, (m_st != 0), cyc);
      end
      if ({all_good, dev_rst_n, powered_on} !== {m_ag, m_rstn, m_pon}) begin
        miscmp++;
        $display("FAIL R8/R9 good/rst/on act=%b%b%b exp=%b%b%b cyc=%0d",
                 all_good, dev_rst_n, powered_on, m_ag, m_rstn, m_pon, cyc);
      end
      if ({fault, fault_rail} !== {m_flt, 3'(m_frail)}) begin
        miscmp++;
        $display("FAIL R6/R7/R10/R11 fault act=%b/%0d exp=%b/%0d cyc=%0d",
                 fault, fault_rail, m_flt, m_frail, cyc);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic request(input bit on);
    @(negedge clk);
    req = 1'b1; req_on = on;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 30000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      miscmp++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bit saw_ok, saw_flt;
    saw_ok = 0; saw_flt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rail_en", 8'(rail_en), 8'h10);
    chk("R1 all_good/dev_rst_n", {6'd0, all_good, dev_rst_n}, 8'h0);
    chk("R1 busy/ack/on/fault", {4'd0, busy, ack, powered_on, fault}, 8'h0);

    // R3 R8 normal power-up
    request(1);
    chk("R2 ack on accept", 8'(ack), 8'h1);
    chk("R3 reset low at start", 8'(dev_rst_n), 8'h0);
    repeat (20) @(negedge clk);
    request(0);                       // R2: ignored while busy
    chk("R2 no ack while busy", 8'(ack), 8'h0);
    wait_idle();
    chk("R8 powered_on", 8'(powered_on), 8'h1);
    chk("R4 enables with rail 4 low", 8'(rail_en), 8'h0f);
    chk("R8 reset released", 8'(dev_rst_n), 8'h1);

    // R9 power-down
    request(0);
    chk("R9 reset dropped", {6'd0, dev_rst_n, all_good}, 8'h0);
    wait_idle();
    chk("R9 all rails off", 8'(rail_en), 8'h10);
    chk("R9 no fault", 8'(fault), 8'h0);

    // R7 rollback on stuck rail 2
    stuck_lo[2] = 1;
    request(1);
    wait_idle();
    chk("R7 fault set", 8'(fault), 8'h1);
    chk("R7 fault rail", 8'(fault_rail), 8'h2);
    chk("R7 rails off after rollback", 8'(rail_en), 8'h10);
    chk("R7 device held", {5'd0, all_good, dev_rst_n, powered_on}, 8'h0);

    // R11 fault holds while idle, clears on accept
    repeat (60) @(negedge clk);
    chk("R11 fault held", {4'd0, fault, fault_rail}, 8'h0a);
    stuck_lo[2] = 0;
    request(1);
    chk("R11 fault cleared on accept", 8'(fault), 8'h0);
    wait_idle();
    chk("R8 powered after retry", 8'(powered_on), 8'h1);

    // R10 power-down with rails 3 and 1 stuck high: first fault kept
    stuck_hi[3] = 1; stuck_hi[1] = 1;
    request(0);
    wait_idle();
    chk("R10 fault on down", 8'(fault), 8'h1);
    chk("R10 first faulty rail kept", 8'(fault_rail), 8'h3);
    chk("R10 sequence carried to end", 8'(rail_en), 8'h10);
    stuck_hi[3] = 0; stuck_hi[1] = 0;
    repeat (10) @(negedge clk);

    // R6 sweep latency of rail 0 across the timeout boundary
    for (int l = 106; l <= 130; l++) begin
      lat[0] = l;
      request(1);
      wait_idle();
      if (powered_on) saw_ok = 1;
      if (fault) saw_flt = 1;
      request(0);
      wait_idle();
      repeat (8) @(negedge clk);
    end
    chk("R6 boundary gave both outcomes", {6'd0, saw_ok, saw_flt}, 8'h3);
    lat[0] = 2;

    // R2 request held across the cycle busy falls
    @(negedge clk);
    req = 1'b1; req_on = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R2 re-accept when busy falls", {6'd0, ack, busy}, 8'h3);
    wait_idle();
    chk("R9 rails off at end", 8'(rail_en), 8'h10);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule